// File: doc/BRIEF.md
# Average-Age Block Reclaimer

This block keeps bookkeeping for a table of cached translation blocks: a last-use stamp, a valid bit and a reference count for each entry. It then frees entries on request. A use strobe records a caller-supplied cycle number as the entry's stamp and marks the entry valid. Acquire and release strobes, one bit per entry, track how many in-flight operations still point into each block.

When `reclaim_start` is seen while the block is idle, a controller runs two scans, one entry per cycle. The tally scan visits every entry and, over the valid ones, collects the smallest stamp, the largest stamp, the sum and the count. A single divide step then forms the rounded-down mean. The sweep scan strobes an eviction for each valid entry whose stamp is strictly below that mean and whose reference count is zero, and it clears that entry's valid bit. A one-cycle `done` closes the run, and the three statistics stay on the ports after it.

The controller states are IDLE, TALLY, DIVIDE, SWEEP and FINISH:
- IDLE goes to TALLY on `reclaim_start`.
- TALLY goes to DIVIDE after the last entry.
- DIVIDE goes to FINISH when no entry was valid, and to SWEEP otherwise.
- SWEEP goes to FINISH after the last entry.
- FINISH returns to IDLE.

Top module: `block_reclaimer`

## Requirements
- R1: A cycle with `use_valid` high writes `use_stamp` into entry `use_idx` and sets that entry's `entry_valid` bit from the next cycle on.
- R2: An acquire bit raises that entry's reference count by one and a release bit lowers it by one. Acquire and release on the same entry in the same cycle leave the count unchanged. `ref_busy[i]` is high exactly while entry i's count is nonzero.
- R3: A release on an entry whose count is zero, without an acquire on that entry in the same cycle, leaves the count at zero. It raises `rel_err` for the one following cycle. `rel_err` stays low otherwise.
- R4: At `done`, `min_stamp`, `max_stamp` and `avg_stamp` hold the smallest stamp, the largest stamp and the floor of the sum divided by the count, each taken over the entries that were valid during the tally scan.
- R5: The sweep scan visits entries in ascending index order. It strobes `evict_vec` one-hot for each valid entry with a stamp strictly below `avg_stamp` and a zero count, and that entry's `entry_valid` bit is low from the next cycle on. An entry whose stamp equals the mean is kept.
- R6: An entry with a nonzero reference count is never evicted.
- R7: A reclaim over zero valid entries skips the sweep, evicts nothing, reports all three statistics as 0, and raises `done` N+1 cycles after the accepting edge, where N is the table size.
- R8: When at least one entry is valid, `done` is high for exactly one cycle, 2N+1 clock edges after the edge that accepts `reclaim_start`. `busy` is high from the accepting edge through the `done` cycle. A `reclaim_start` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| use_valid | input | 1 | Use strobe |
| use_idx | input | IDX_W | Entry the use strobe targets |
| use_stamp | input | TS_W | Cycle number recorded by a use |
| acq_vec | input | ENTRIES | Per-entry acquire strobes |
| rel_vec | input | ENTRIES | Per-entry release strobes |
| reclaim_start | input | 1 | Request a reclaim run |
| evict_vec | output | ENTRIES | Per-entry eviction strobes |
| done | output | 1 | One-cycle end-of-run pulse |
| busy | output | 1 | A run is in progress |
| min_stamp | output | TS_W | Oldest stamp of the last run |
| max_stamp | output | TS_W | Newest stamp of the last run |
| avg_stamp | output | TS_W | Rounded-down mean stamp of the last run |
| entry_valid | output | ENTRIES | Per-entry valid bits |
| ref_busy | output | ENTRIES | Per-entry nonzero reference count |
| rel_err | output | 1 | Release-at-zero error pulse |

## Verification
The bench builds a table in which one entry's stamp equals the mean exactly. A design that evicted on less-or-equal would drop that entry. It also builds a mean with a fractional part, where rounding up would evict an entry the floor keeps. A referenced entry below the mean is checked for survival. The bench also covers:
- an empty table, where a design that still ran the sweep would finish eight cycles late;
- a reclaim request made mid-run, which must not add a second `done`;
- a release at zero, where a wrapping counter would show up as a busy reference;
- paired acquire and release strobes, which must cancel.

// File: rtl/br_pkg.sv
package br_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TALLY,
        ST_DIVIDE,
        ST_SWEEP,
        ST_FINISH
    } br_state_e;

endpackage

// File: rtl/br_entry_table.sv
module br_entry_table #(
    parameter int ENTRIES = 8,
    parameter int TS_W    = 16,
    parameter int REF_W   = 4,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               use_valid,
    input  logic [IDX_W-1:0]   use_idx,
    input  logic [TS_W-1:0]    use_stamp,
    input  logic [ENTRIES-1:0] acq_vec,
    input  logic [ENTRIES-1:0] rel_vec,
    input  logic [ENTRIES-1:0] evict_vec,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRIES-1:0] entry_valid,
    output logic [ENTRIES-1:0] ref_busy,
    output logic               rel_err,
    output logic               rd_valid,
    output logic               rd_free,
    output logic [TS_W-1:0]    rd_stamp
);

    localparam logic [REF_W-1:0] REF_MAX = '1;

    logic [ENTRIES*TS_W-1:0] stamp_flat;
    logic [ENTRIES-1:0]      err_vec;
    logic                    rel_err_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic [TS_W-1:0]  stamp_q;
        logic             valid_q;
        logic [REF_W-1:0] cnt_q;
        logic             hit;
        logic             inc;
        logic             dec;

        assign hit = use_valid && (use_idx == IDX_W'(g));
        assign inc = acq_vec[g] && !rel_vec[g];
        assign dec = rel_vec[g] && !acq_vec[g] && (cnt_q != '0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stamp_q <= '0;
                valid_q <= 1'b0;
            end else if (hit) begin
                stamp_q <= use_stamp;
                valid_q <= 1'b1;
            end else if (evict_vec[g]) begin
                valid_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (inc && (cnt_q != REF_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (dec) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign err_vec[g]                     = rel_vec[g] && !acq_vec[g] && (cnt_q == '0);
        assign stamp_flat[g*TS_W +: TS_W]     = stamp_q;
        assign entry_valid[g]                 = valid_q;
        assign ref_busy[g]                    = (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_err_q <= 1'b0;
        end else begin
            rel_err_q <= |err_vec;
        end
    end

    assign rel_err  = rel_err_q;
    assign rd_valid = entry_valid[rd_idx];
    assign rd_free  = !ref_busy[rd_idx];
    assign rd_stamp = stamp_flat[int'(rd_idx)*TS_W +: TS_W];

endmodule

// File: rtl/br_tally.sv
module br_tally #(
    parameter int TS_W  = 16,
    parameter int CNT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            visit,
    input  logic            smp_valid,
    input  logic [TS_W-1:0] smp_stamp,
    input  logic            avg_load,
    output logic [TS_W-1:0] min_stamp,
    output logic [TS_W-1:0] max_stamp,
    output logic [TS_W-1:0] avg_stamp,
    output logic            none_valid
);

    localparam int SUM_W = TS_W + CNT_W;

    logic [TS_W-1:0]  min_q;
    logic [TS_W-1:0]  max_q;
    logic [TS_W-1:0]  avg_q;
    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] quot;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            min_q <= '1;
            max_q <= '0;
            sum_q <= '0;
            cnt_q <= '0;
        end else if (visit && smp_valid) begin
            if (smp_stamp < min_q) begin
                min_q <= smp_stamp;
            end
            if (smp_stamp > max_q) begin
                max_q <= smp_stamp;
            end
            sum_q <= sum_q + SUM_W'(smp_stamp);
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (cnt_q == '0) begin
            quot = '0;
        end else begin
            quot = sum_q / SUM_W'(cnt_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            avg_q <= '0;
        end else if (avg_load) begin
            avg_q <= quot[TS_W-1:0];
        end
    end

    assign none_valid = (cnt_q == '0);
    assign min_stamp  = none_valid ? '0 : min_q;
    assign max_stamp  = max_q;
    assign avg_stamp  = avg_q;

endmodule

// File: rtl/br_ctrl.sv
module br_ctrl
    import br_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TS_W    = 16,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reclaim_start,
    input  logic               none_valid,
    input  logic               rd_valid,
    input  logic               rd_free,
    input  logic [TS_W-1:0]    rd_stamp,
    input  logic [TS_W-1:0]    avg_stamp,
    output logic [IDX_W-1:0]   scan_idx,
    output logic               tally_clear,
    output logic               tally_visit,
    output logic               avg_load,
    output logic [ENTRIES-1:0] evict_vec,
    output logic               busy,
    output logic               done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    br_state_e        state_q;
    br_state_e        state_d;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || (state_q != state_d)) begin
            idx_q <= '0;
        end else if ((state_q == ST_TALLY) || (state_q == ST_SWEEP)) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (reclaim_start) state_d = ST_TALLY;
            ST_TALLY:  if (idx_q == LAST) state_d = ST_DIVIDE;
            ST_DIVIDE: state_d = none_valid ? ST_FINISH : ST_SWEEP;
            ST_SWEEP:  if (idx_q == LAST) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tally_clear = 1'b0;
        tally_visit = 1'b0;
        avg_load    = 1'b0;
        evict_vec   = '0;
        busy        = 1'b1;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy        = 1'b0;
                tally_clear = reclaim_start;
            end
            ST_TALLY:  tally_visit = 1'b1;
            ST_DIVIDE: avg_load = 1'b1;
            ST_SWEEP: begin
                if (rd_valid && rd_free && (rd_stamp < avg_stamp)) begin
                    evict_vec[idx_q] = 1'b1;
                end
            end
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign scan_idx = idx_q;

endmodule

// File: rtl/block_reclaimer.sv
module block_reclaimer #(
    parameter int ENTRIES = 8,
    parameter int TS_W    = 16,
    parameter int REF_W   = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               use_valid,
    input  logic [IDX_W-1:0]   use_idx,
    input  logic [TS_W-1:0]    use_stamp,
    input  logic [ENTRIES-1:0] acq_vec,
    input  logic [ENTRIES-1:0] rel_vec,
    input  logic               reclaim_start,
    output logic [ENTRIES-1:0] evict_vec,
    output logic               done,
    output logic               busy,
    output logic [TS_W-1:0]    min_stamp,
    output logic [TS_W-1:0]    max_stamp,
    output logic [TS_W-1:0]    avg_stamp,
    output logic [ENTRIES-1:0] entry_valid,
    output logic [ENTRIES-1:0] ref_busy,
    output logic               rel_err
);

    localparam int CNT_W = $clog2(ENTRIES + 1);

    logic [IDX_W-1:0] scan_idx;
    logic             rd_valid;
    logic             rd_free;
    logic [TS_W-1:0]  rd_stamp;
    logic             tally_clear;
    logic             tally_visit;
    logic             avg_load;
    logic             none_valid;

    br_entry_table #(
        .ENTRIES(ENTRIES), .TS_W(TS_W), .REF_W(REF_W), .IDX_W(IDX_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_valid  (use_valid),
        .use_idx    (use_idx),
        .use_stamp  (use_stamp),
        .acq_vec    (acq_vec),
        .rel_vec    (rel_vec),
        .evict_vec  (evict_vec),
        .rd_idx     (scan_idx),
        .entry_valid(entry_valid),
        .ref_busy   (ref_busy),
        .rel_err    (rel_err),
        .rd_valid   (rd_valid),
        .rd_free    (rd_free),
        .rd_stamp   (rd_stamp)
    );

    br_tally #(
        .TS_W(TS_W), .CNT_W(CNT_W)
    ) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tally_clear),
        .visit     (tally_visit),
        .smp_valid (rd_valid),
        .smp_stamp (rd_stamp),
        .avg_load  (avg_load),
        .min_stamp (min_stamp),
        .max_stamp (max_stamp),
        .avg_stamp (avg_stamp),
        .none_valid(none_valid)
    );

    br_ctrl #(
        .ENTRIES(ENTRIES), .TS_W(TS_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reclaim_start(reclaim_start),
        .none_valid   (none_valid),
        .rd_valid     (rd_valid),
        .rd_free      (rd_free),
        .rd_stamp     (rd_stamp),
        .avg_stamp    (avg_stamp),
        .scan_idx     (scan_idx),
        .tally_clear  (tally_clear),
        .tally_visit  (tally_visit),
        .avg_load     (avg_load),
        .evict_vec    (evict_vec),
        .busy         (busy),
        .done         (done)
    );

endmodule

// File: rtl/br_reclaimer_chk.sv
module br_reclaimer_chk #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               use_valid,
    input logic [IDX_W-1:0]   use_idx,
    input logic [ENTRIES-1:0] acq_vec,
    input logic [ENTRIES-1:0] rel_vec,
    input logic [ENTRIES-1:0] evict_vec,
    input logic               done,
    input logic               busy,
    input logic [ENTRIES-1:0] entry_valid,
    input logic [ENTRIES-1:0] ref_busy,
    input logic               rel_err
);

    // R1
    use_marks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_valid |=> entry_valid[$past(use_idx)]);

    // R2
    paired_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_vec == rel_vec) |=> $stable(ref_busy));

    // R3
    rel_err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rel_vec & ~acq_vec & ~ref_busy)) |=> rel_err);

    // R3
    rel_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(rel_vec & ~acq_vec & ~ref_busy)) |=> !rel_err);

    // R5
    evict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evict_vec));

    // R5
    evict_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|evict_vec) && !use_valid) |=> ((entry_valid & $past(evict_vec)) == '0));

    // R6
    evict_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_vec & ref_busy) == '0);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    evict_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evict_vec) |-> busy);

    // R8
    done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

bind block_reclaimer br_reclaimer_chk #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .use_valid  (use_valid),
    .use_idx    (use_idx),
    .acq_vec    (acq_vec),
    .rel_vec    (rel_vec),
    .evict_vec  (evict_vec),
    .done       (done),
    .busy       (busy),
    .entry_valid(entry_valid),
    .ref_busy   (ref_busy),
    .rel_err    (rel_err)
);

// File: tb/sim_block_reclaimer.sv
module sim_block_reclaimer;

    localparam int N    = 8;
    localparam int TS_W = 16;
    localparam int IW   = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            use_valid;
    logic [IW-1:0]   use_idx;
    logic [TS_W-1:0] use_stamp;
    logic [N-1:0]    acq_vec;
    logic [N-1:0]    rel_vec;
    logic            reclaim_start;
    logic [N-1:0]    evict_vec;
    logic            done;
    logic            busy;
    logic [TS_W-1:0] min_stamp;
    logic [TS_W-1:0] max_stamp;
    logic [TS_W-1:0] avg_stamp;
    logic [N-1:0]    entry_valid;
    logic [N-1:0]    ref_busy;
    logic            rel_err;

    always #5 clk = ~clk;

    block_reclaimer #(.ENTRIES(N), .TS_W(TS_W), .REF_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .use_valid(use_valid), .use_idx(use_idx),
        .use_stamp(use_stamp), .acq_vec(acq_vec), .rel_vec(rel_vec),
        .reclaim_start(reclaim_start), .evict_vec(evict_vec), .done(done),
        .busy(busy), .min_stamp(min_stamp), .max_stamp(max_stamp),
        .avg_stamp(avg_stamp), .entry_valid(entry_valid), .ref_busy(ref_busy),
        .rel_err(rel_err)
    );

    typedef struct {
        bit is_done;
        int idx;
        int mn;
        int mx;
        int av;
        int lat;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   t0 = 0;
    bit   finished = 0;

    int   m_ts[N];
    bit   m_valid[N];
    int   m_ref[N];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    // Monitor: pops scoreboard items as evictions and done appear
    exp_t e;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (evict_vec[i]) begin
                    if (sb.size() == 0) begin
                        chk(0, "R5", "unexpected eviction index", i, -1);
                    end else begin
                        e = sb.pop_front();
                        chk(!e.is_done && (e.idx == i), "R5", "eviction index in order",
                            i, e.is_done ? -1 : e.idx);
                    end
                end
            end
            if (done) begin
                if (sb.size() == 0) begin
                    chk(0, "R8", "unexpected done", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk(e.is_done, "R5", "done before expected eviction", -1, e.idx);
                    chk(cyc - t0 == e.lat, "R8", "done latency", cyc - t0, e.lat);
                    chk(int'(min_stamp) == e.mn, "R4", "min_stamp", min_stamp, e.mn);
                    chk(int'(max_stamp) == e.mx, "R4", "max_stamp", max_stamp, e.mx);
                    chk(int'(avg_stamp) == e.av, "R4", "avg_stamp", avg_stamp, e.av);
                end
            end
        end
    end

    task automatic do_use(input int idx, input int ts);
        @(negedge clk);
        use_valid = 1'b1;
        use_idx   = IW'(idx);
        use_stamp = TS_W'(ts);
        @(negedge clk);
        use_valid = 1'b0;
        m_ts[idx]    = ts;
        m_valid[idx] = 1;
        chk(entry_valid[idx] == 1'b1, "R1", "entry valid after use", entry_valid[idx], 1);
    endtask

    task automatic do_ref(input logic [N-1:0] acq, input logic [N-1:0] rel);
        bit err_exp = 0;
        logic [N-1:0] busy_exp = '0;
        for (int i = 0; i < N; i++) begin
            if (rel[i] && !acq[i]) begin
                if (m_ref[i] == 0) err_exp = 1;
                else m_ref[i]--;
            end else if (acq[i] && !rel[i] && m_ref[i] < 15) begin
                m_ref[i]++;
            end
            busy_exp[i] = (m_ref[i] != 0);
        end
        @(negedge clk);
        acq_vec = acq;
        rel_vec = rel;
        @(negedge clk);
        acq_vec = '0;
        rel_vec = '0;
        chk(rel_err == err_exp, "R3", "rel_err after strobe", rel_err, err_exp);
        chk(ref_busy == busy_exp, "R2", "ref_busy after strobe", ref_busy, busy_exp);
    endtask

    // Driver: predicts the run from the model, pushes items, starts the run
    task automatic do_reclaim(input bit poke);
        longint sum = 0;
        int cnt = 0;
        int mn = 0;
        int mx = 0;
        int av = 0;
        exp_t it;
        logic [N-1:0] valid_exp = '0;
        for (int i = 0; i < N; i++) begin
            if (m_valid[i]) begin
                if (cnt == 0 || m_ts[i] < mn) mn = m_ts[i];
                if (cnt == 0 || m_ts[i] > mx) mx = m_ts[i];
                sum += m_ts[i];
                cnt++;
            end
        end
        if (cnt != 0) av = int'(sum / cnt);
        if (cnt != 0) begin
            for (int i = 0; i < N; i++) begin
                if (m_valid[i] && m_ts[i] < av && m_ref[i] == 0) begin
                    it = '{is_done: 0, idx: i, mn: 0, mx: 0, av: 0, lat: 0};
                    sb.push_back(it);
                    m_valid[i] = 0;
                end
            end
        end
        it = '{is_done: 1, idx: -1, mn: mn, mx: mx, av: av,
               lat: (cnt == 0) ? N + 1 : 2 * N + 1};
        sb.push_back(it);
        for (int i = 0; i < N; i++) valid_exp[i] = m_valid[i];

        @(negedge clk);
        reclaim_start = 1'b1;
        @(negedge clk);
        reclaim_start = 1'b0;
        t0 = cyc;
        chk(busy == 1'b1, "R8", "busy after start", busy, 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            reclaim_start = 1'b1;
            @(negedge clk);
            reclaim_start = 1'b0;
        end
        repeat (2 * N + 4) @(negedge clk);
        chk(sb.size() == 0, "R8", "items left after run", sb.size(), 0);
        chk(busy == 1'b0, "R8", "idle after run", busy, 0);
        chk(entry_valid == valid_exp, "R5", "valid bits after run", entry_valid, valid_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        use_valid = 1'b0;
        use_idx = '0;
        use_stamp = '0;
        acq_vec = '0;
        rel_vec = '0;
        reclaim_start = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_ts[i] = 0;
            m_valid[i] = 0;
            m_ref[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk(entry_valid == '0, "R1", "reset valid bits", entry_valid, 0);
        chk(ref_busy == '0, "R2", "reset ref_busy", ref_busy, 0);
        chk(done == 1'b0 && busy == 1'b0, "R8", "reset done/busy", {done, busy}, 0);
        chk(evict_vec == '0, "R5", "reset evict", evict_vec, 0);

        // R7: empty table
        do_reclaim(0);
        chk(avg_stamp == 0 && min_stamp == 0, "R7", "empty stats", avg_stamp, 0);

        // R1: a single stamp shows up as all three statistics
        do_use(3, 77);
        do_reclaim(0);
        chk(avg_stamp == 77 && min_stamp == 77 && max_stamp == 77, "R1",
            "single stamp stats", avg_stamp, 77);

        // R4/R6: full table, entry 1 referenced, extra start mid-run (R8)
        for (int i = 0; i < N; i++) do_use(i, 10 * (i + 1));
        do_ref(8'b0000_0010, 8'b0);
        do_reclaim(1);
        chk(avg_stamp == 45, "R4", "mean of 10..80", avg_stamp, 45);
        chk(min_stamp == 10 && max_stamp == 80, "R4", "min/max of 10..80",
            {min_stamp, max_stamp}, {16'd10, 16'd80});
        chk(entry_valid[1] == 1'b1, "R6", "referenced entry kept", entry_valid[1], 1);

        // R3: release at zero; R2: paired strobes and nested counts
        do_ref(8'b0, 8'b0000_0001);
        chk(ref_busy[0] == 1'b0, "R3", "no wrap on release at zero", ref_busy[0], 0);
        do_ref(8'b0000_1000, 8'b0000_1000);
        do_ref(8'b0000_0010, 8'b0000_0010);
        do_ref(8'b0000_0010, 8'b0);
        do_ref(8'b0, 8'b0000_0010);
        chk(ref_busy[1] == 1'b1, "R2", "count two released once", ref_busy[1], 1);

        // R5: an entry equal to the mean is kept
        do_use(5, 55);
        do_reclaim(0);
        chk(avg_stamp == 55, "R5", "exact mean", avg_stamp, 55);
        chk(entry_valid[5] == 1'b1, "R5", "entry equal to mean kept", entry_valid[5], 1);

        // R4: floor of 177/4 is 44, entry at 44 kept
        do_ref(8'b0, 8'b0000_0010);
        do_use(1, 44);
        do_use(5, 45);
        do_use(6, 46);
        do_use(7, 42);
        do_reclaim(0);
        chk(avg_stamp == 44, "R4", "rounded-down mean", avg_stamp, 44);
        chk(entry_valid[1] == 1'b1, "R4", "entry at floor kept", entry_valid[1], 1);

        // R5: released entry now below mean is evicted
        do_reclaim(0);
        chk(entry_valid[1] == 1'b0, "R5", "unreferenced old entry evicted", entry_valid[1], 0);

        summary();
        $finish;
    end

endmodule